// File: doc/BRIEF.md
# Two-Digit Decimal Product Display

The block multiplies two small unsigned operands and shows the product as a two-digit decimal number on a bank of common-anode seven-segment digits. A combinational multiplier forms the binary product. The product is then split into a tens digit (quotient by ten) and a units digit (remainder by ten). One of the two digits is turned into an active-low segment pattern. All digits share a single seven-bit segment bus, so a scanner takes turns driving the units position and the tens position. Each turn lasts a set number of clock cycles.

The segment bus and the active-low digit-enable vector are registered together. The two outputs only change when a scan slot begins, and they change on the same edge. For that reason a lit digit never carries the other digit's pattern. The operands are sampled at the start of each slot. A product below ten keeps its leading zero on the tens position.

Top module: `mul_disp_top`

## Requirements
- R1: The product is opA × opB, with both operands taken as 3-bit unsigned values. The units slot shows product mod 10 and the tens slot shows product div 10.
- R2: When the product is below ten, the tens slot shows the pattern for 0. It is not blanked.
- R3: Segment bits are active low, with seg[0]=a through seg[6]=g. The patterns for digits 0 to 9 are 7'b1000000, 7'b1111001, 7'b0100100, 7'b0110000, 7'b0011001, 7'b0010010, 7'b0000010, 7'b1111000, 7'b0000000 and 7'b0010000. The blank pattern is 7'b1111111.
- R4: The digit enables are active low. During the units slot anode is 8'b11111110, and during the tens slot it is 8'b11111101. Bits 7 to 2 are always 1, and at most one bit is 0.
- R5: Each slot lasts exactly PRESCALE cycles. The slots alternate, and the units slot comes first after reset.
- R6: While the synchronous active-high reset is held, seg is 7'h7F and anode is 8'hFF. The first clock edge with reset low loads the units slot.
- R7: The operands are captured on the edge that starts a slot. An operand change in the middle of a slot has no effect on seg until the next slot begins.
- R8: seg and anode are updated together on a slot's first edge, and both hold steady for the rest of the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opA | input | 3 | First unsigned operand |
| opB | input | 3 | Second unsigned operand |
| seg | output | 7 | Shared segment bus, active low, bit 0 = segment a |
| anode | output | 8 | Digit enables, active low, bit 0 = rightmost digit |

## Verification
Two events can land on the same cycle: an operand change and the load at the start of a slot. The bench changes operands on the cycle just before a load, on the load edge itself, and in the middle of slots. A behavioural model decides the result: it captures the operands only on the edges that its own cycle count marks as slot starts. It then compares the expected segment and enable values against the design on every clock. A reset in the middle of a slot checks that the scan restarts on the units digit.

// File: rtl/mul_disp_pkg.sv
package mul_disp_pkg;

  typedef struct packed {
    logic load;     // first cycle of a scan slot
    logic selTens;  // 0 = units slot, 1 = tens slot
  } scanCtl_t;

  localparam logic [6:0] SEG_BLANK = 7'b1111111;

  // active-low pattern, bit 0 = segment a ... bit 6 = segment g
  function automatic logic [6:0] bcdToSeg(input logic [3:0] digit);
    logic [6:0] pat;
    case (digit)
      4'd0:    pat = 7'b1000000;
      4'd1:    pat = 7'b1111001;
      4'd2:    pat = 7'b0100100;
      4'd3:    pat = 7'b0110000;
      4'd4:    pat = 7'b0011001;
      4'd5:    pat = 7'b0010010;
      4'd6:    pat = 7'b0000010;
      4'd7:    pat = 7'b1111000;
      4'd8:    pat = 7'b0000000;
      4'd9:    pat = 7'b0010000;
      default: pat = SEG_BLANK;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/mul_disp_ctrl.sv
module mul_disp_ctrl
  import mul_disp_pkg::*;
#(
  parameter int PRESCALE = 50000
) (
  input  logic     clk,
  input  logic     rst,
  output scanCtl_t ctl
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] slotCnt;
  logic             selTens;

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt <= '0;
      selTens <= 1'b0;
    end else if (slotCnt == LAST) begin
      slotCnt <= '0;
      selTens <= ~selTens;
    end else begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.load    = (slotCnt == '0);
    ctl.selTens = selTens;
  end
endmodule

// File: rtl/mul_disp_path.sv
module mul_disp_path
  import mul_disp_pkg::*;
#(
  parameter int OP_W   = 3,
  parameter int DIGITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  scanCtl_t          ctl,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [6:0]        seg,
  output logic [DIGITS-1:0] anode
);
  localparam int PROD_W = 2 * OP_W;
  localparam logic [PROD_W-1:0] TEN = PROD_W'(10);

  logic [PROD_W-1:0] product;
  logic [3:0]        tensDigit;
  logic [3:0]        unitsDigit;
  logic [3:0]        shownDigit;
  logic [DIGITS-1:0] nextAnode;
  logic [6:0]        segQ;
  logic [DIGITS-1:0] anodeQ;

  always_comb begin
    product    = PROD_W'(opA) * PROD_W'(opB);
    tensDigit  = 4'(product / TEN);
    unitsDigit = 4'(product % TEN);
    shownDigit = ctl.selTens ? tensDigit : unitsDigit;
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_enable
    if (i == 0) begin : g_units
      assign nextAnode[i] = ctl.selTens;
    end else if (i == 1) begin : g_tens
      assign nextAnode[i] = ~ctl.selTens;
    end else begin : g_idle
      assign nextAnode[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      segQ   <= SEG_BLANK;
      anodeQ <= '1;
    end else if (ctl.load) begin
      segQ   <= bcdToSeg(shownDigit);
      anodeQ <= nextAnode;
    end
  end

  assign seg   = segQ;
  assign anode = anodeQ;
endmodule

// File: rtl/mul_disp_top.sv
module mul_disp_top
  import mul_disp_pkg::*;
#(
  parameter int OP_W     = 3,
  parameter int DIGITS   = 8,
  parameter int PRESCALE = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] opA,
  input  logic [2:0] opB,
  output logic [6:0] seg,
  output logic [7:0] anode
);
  scanCtl_t ctl;

  mul_disp_ctrl #(.PRESCALE(PRESCALE)) ctrl_i (
    .clk (clk),
    .rst (rst),
    .ctl (ctl)
  );

  mul_disp_path #(.OP_W(OP_W), .DIGITS(DIGITS)) path_i (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .opA   (opA),
    .opB   (opB),
    .seg   (seg),
    .anode (anode)
  );
endmodule

// File: rtl/mul_disp_chk.sv
module mul_disp_chk #(
  parameter int PRESCALE = 50000
) (
  input logic       clk,
  input logic       rst,
  input logic [6:0] seg,
  input logic [7:0] anode
);
  logic [7:0] prevAnode;
  int         holdCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevAnode <= 8'hFF;
      holdCnt   <= 0;
    end else begin
      prevAnode <= anode;
      holdCnt   <= (anode != prevAnode) ? 0 : holdCnt + 1;
    end
  end

  AST_IDLE_DIGITS_OFF: assert property (@(posedge clk) disable iff (rst) anode[7:2] == 6'b111111); // R4
  AST_ONE_DIGIT_LIT:   assert property (@(posedge clk) disable iff (rst) $onehot0(~anode)); // R4
  AST_SEG_WITH_ANODE:  assert property (@(posedge clk) disable iff (rst) !$stable(seg) |-> !$stable(anode)); // R8
  AST_LIT_NOT_BLANK:   assert property (@(posedge clk) disable iff (rst) anode != 8'hFF |-> seg != 7'h7F); // R3
  AST_SLOT_BOUNDED:    assert property (@(posedge clk) disable iff (rst) holdCnt < PRESCALE); // R5
endmodule

bind mul_disp_top mul_disp_chk #(.PRESCALE(PRESCALE)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .seg   (seg),
  .anode (anode)
);

// File: tb/mul_disp_top_tb_top.sv
`timescale 1ns/1ps
module mul_disp_top_tb_top;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] opA = '0;
  logic [2:0] opB = '0;
  logic [6:0] seg;
  logic [7:0] anode;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  string curReq = "R6";

  int         edgeCnt = 0;
  logic [6:0] expSeg  = 7'h7F;
  logic [7:0] expAn   = 8'hFF;

  always #2.5 clk = ~clk;

  mul_disp_top #(.PRESCALE(P)) dut_i (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .seg(seg), .anode(anode)
  );

  // R3 patterns
  function automatic logic [6:0] patOf(input int d);
    case (d)
      0: return 7'b1000000;
      1: return 7'b1111001;
      2: return 7'b0100100;
      3: return 7'b0110000;
      4: return 7'b0011001;
      5: return 7'b0010010;
      6: return 7'b0000010;
      7: return 7'b1111000;
      8: return 7'b0000000;
      9: return 7'b0010000;
      default: return 7'b1111111;
    endcase
  endfunction

  // reference model: slot start every P edges after reset, units first
  always @(posedge clk) begin
    if (rst) begin
      edgeCnt = 0;
      expSeg  = 7'h7F;
      expAn   = 8'hFF;
    end else begin
      if (edgeCnt % P == 0) begin
        automatic int prod = int'(opA) * int'(opB);
        automatic bit tens = ((edgeCnt / P) % 2) == 1;
        expSeg = patOf(tens ? prod / 10 : prod % 10);
        expAn  = tens ? 8'hFD : 8'hFE;
      end
      edgeCnt++;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    vectors++;
    if (anode !== expAn) begin
      fails++;
      $display("FAIL R4/R5 anode: actual %b expected %b (phase %s)", anode, expAn, curReq);
    end
    if (seg !== expSeg) begin
      fails++;
      $display("FAIL %s seg: actual %b expected %b (a=%0d b=%0d)", curReq, seg, expSeg, opA, opB);
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R6: reset state
    waitCycles(3);
    @(negedge clk); rst = 1'b0;
    // R1 and R3: every operand pair, held two full slots
    curReq = "R1";
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        opA = 3'(a); opB = 3'(b);
        waitCycles(2 * P);
      end
    end
    // R2: products below ten keep tens at 0
    curReq = "R2";
    for (int b = 0; b < 8; b++) begin
      opA = 3'd1; opB = 3'(b);
      waitCycles(2 * P);
    end
    // R7: changes off slot alignment, incl. just before and on load edges
    curReq = "R7";
    for (int k = 0; k < 40; k++) begin
      opA = 3'((k * 5 + 3) % 8); opB = 3'((k * 3 + 1) % 8);
      waitCycles(1 + (k % (P + 1)));
    end
    // R6: reset in the middle of a slot, scan restarts on units
    curReq = "R6";
    waitCycles(1);
    rst = 1'b1;
    waitCycles(2);
    rst = 1'b0;
    // R5 and R8: steady operands, slot length and joint updates
    curReq = "R5";
    opA = 3'd7; opB = 3'd6;
    waitCycles(6 * P);
    curReq = "R8";
    opA = 3'd3; opB = 3'd4;
    waitCycles(4 * P + 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule